// File: doc/BRIEF.md
# UART interrupt request combiner

This block merges the interrupt-worthy events of one UART channel into a single active-low request line for a processor. The six events are: transmit data register empty, transmitter idle, receive data available, receive overrun, address match, and a wake-up caused by a falling edge on the receive pin. The four status-flag events arrive as levels from the UART. The address match arrives as a pulse. The wake-up is derived inside the block from the raw receive pin.

Each event is masked by an enable. The two transmit events have one enable each. The two receive events share one enable. Address match has an enable of its own. Wake-up needs its own enable and the shared receive enable, and it is armed only while the UART's functional clock is reported as switched off.

The whole block runs on an always-on clock, so it can see a receive-pin edge while the UART clock is gated. The request is a one-cycle low pulse, raised when the OR of all enabled events goes from false to true.

Top module: `uart_irq_combiner`

## Requirements
- R1: With `en_txe`=1, a rise of `txe_flag` gives one request pulse. With `en_txe`=0 it gives none.
- R2: With `en_txi`=1, a rise of `txi_flag` gives one request pulse. With `en_txi`=0 it gives none.
- R3: A rise of `rxa_flag` or of `rxo_flag` gives one request pulse when the shared enable `en_rx`=1, and none when `en_rx`=0.
- R4: An `addr_hit` pulse gives one request pulse when `en_addr`=1, and none when `en_addr`=0.
- R5: A falling edge on `rx_pin` gives one request pulse when `clk_off`=1, `en_wake`=1 and `en_rx`=1. If the pin is first sampled low at clock edge n, `irq_n` is low in the cycle that follows edge n+SYNC_STAGES.
- R6: A falling edge on `rx_pin` gives no request while `clk_off`=0. A rising edge on `rx_pin` never gives a request.
- R7: `irq_n` is active low, is driven from a flop, and stays low for exactly one clock cycle per request.
- R8: A request is issued only on a false-to-true change of the OR of all enabled events. A level held high gives one pulse and no more. An event that arrives while another enabled event is still active gives no new pulse.
- R9: While `rst_n` is low, `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txe_flag | input | 1 | Transmit data register empty status |
| txi_flag | input | 1 | Transmitter idle status |
| rxa_flag | input | 1 | Receive data available status |
| rxo_flag | input | 1 | Receive overrun status |
| addr_hit | input | 1 | Address match pulse from the receiver |
| rx_pin | input | 1 | Raw asynchronous receive pin |
| clk_off | input | 1 | High while the UART functional clock is stopped |
| en_txe | input | 1 | Enable for transmit-empty events |
| en_txi | input | 1 | Enable for transmitter-idle events |
| en_rx | input | 1 | Shared enable for receive events, also needed for wake-up |
| en_addr | input | 1 | Enable for address-match events |
| en_wake | input | 1 | Enable for receive-pin wake-up |
| irq_n | output | 1 | One-cycle active-low interrupt request |

## Verification
The bench builds the block with SYNC_STAGES=2, the default. A wake-up edge then reaches `irq_n` in three cycles, so the bench can measure that latency exactly and keep every observation window short. The bench sweeps all 32 combinations of the five enables against every event type, including wake-up with the UART clock running. With windows this short, the whole cross product runs in a few thousand cycles. A separate overlap scenario holds one event active while a second one arrives, to show that no further pulse is issued.

// File: rtl/uart_irq_combiner.sv
module uart_irq_combiner #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txe_flag,
  input  logic txi_flag,
  input  logic rxa_flag,
  input  logic rxo_flag,
  input  logic addr_hit,
  input  logic rx_pin,
  input  logic clk_off,
  input  logic en_txe,
  input  logic en_txi,
  input  logic en_rx,
  input  logic en_addr,
  input  logic en_wake,
  output logic irq_n
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] rx_sync;
  logic          rx_last;
  logic          any_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_sync[g] <= 1'b1;
        else if (g == 0) rx_sync[g] <= rx_pin;
        else rx_sync[g] <= rx_sync[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_last <= 1'b1;
    else rx_last <= rx_sync[LAST];
  end

  wire rx_fall   = rx_last & ~rx_sync[LAST];
  wire tx_src    = (txe_flag & en_txe) | (txi_flag & en_txi);
  wire rx_src    = (rxa_flag | rxo_flag) & en_rx;
  wire addr_src  = addr_hit & en_addr;
  wire wake_src  = rx_fall & clk_off & en_wake & en_rx;
  wire any_src   = tx_src | rx_src | addr_src | wake_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_q <= 1'b0;
      irq_n <= 1'b1;
    end else begin
      any_q <= any_src;
      irq_n <= ~(any_src & ~any_q);
    end
  end

endmodule

// File: rtl/uart_irq_combiner_chk.sv
module uart_irq_combiner_chk (
  input logic clk,
  input logic rst_n,
  input logic txe_flag,
  input logic txi_flag,
  input logic rxa_flag,
  input logic rxo_flag,
  input logic addr_hit,
  input logic clk_off,
  input logic en_txe,
  input logic en_txi,
  input logic en_rx,
  input logic en_addr,
  input logic en_wake,
  input logic irq_n
);

  // R7
  pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |=> irq_n);

  // R9
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> irq_n);

  // R8
  held_txe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(txe_flag & en_txe) && $past(txe_flag & en_txe, 2)) |-> irq_n);

  // R3
  rx_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!en_rx) && $past(!(txe_flag & en_txe)) && $past(!(txi_flag & en_txi))
     && $past(!(addr_hit & en_addr))) |-> irq_n);

  // R6
  no_source_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!clk_off) && $past(!(txe_flag & en_txe)) && $past(!(txi_flag & en_txi))
     && $past(!((rxa_flag | rxo_flag) & en_rx)) && $past(!(addr_hit & en_addr)))
    |-> irq_n);

  // R5
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!(en_wake & en_rx)) && $past(!(txe_flag & en_txe)) && $past(!(txi_flag & en_txi))
     && $past(!((rxa_flag | rxo_flag) & en_rx)) && $past(!(addr_hit & en_addr)))
    |-> irq_n);

endmodule

bind uart_irq_combiner uart_irq_combiner_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txe_flag(txe_flag), .txi_flag(txi_flag),
  .rxa_flag(rxa_flag), .rxo_flag(rxo_flag), .addr_hit(addr_hit),
  .clk_off(clk_off), .en_txe(en_txe), .en_txi(en_txi), .en_rx(en_rx),
  .en_addr(en_addr), .en_wake(en_wake), .irq_n(irq_n)
);

// File: tb/sim_uart_irq_combiner.sv
`timescale 1ns/1ps
module sim_uart_irq_combiner;
  localparam int SYNC = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic txe_flag = 0, txi_flag = 0, rxa_flag = 0, rxo_flag = 0, addr_hit = 0;
  logic rx_pin = 1, clk_off = 0;
  logic en_txe = 0, en_txi = 0, en_rx = 0, en_addr = 0, en_wake = 0;
  logic irq_n;

  int checks = 0, errors = 0;
  int pulses = 0, lows = 0;
  logic prev = 1'b1;
  bit done = 0;

  always #5 clk = ~clk;

  uart_irq_combiner #(.SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .txe_flag(txe_flag), .txi_flag(txi_flag),
    .rxa_flag(rxa_flag), .rxo_flag(rxo_flag), .addr_hit(addr_hit),
    .rx_pin(rx_pin), .clk_off(clk_off), .en_txe(en_txe), .en_txi(en_txi),
    .en_rx(en_rx), .en_addr(en_addr), .en_wake(en_wake), .irq_n(irq_n)
  );

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (!irq_n) begin
        lows++;
        if (prev) pulses++;
      end
      prev = irq_n;
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_win();
    pulses = 0;
    lows = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    string tag;
    int expv;
    int lat;
    idle(3);
    // R9
    check("R9", int'(irq_n), 1, "irq_n in reset");
    @(negedge clk) rst_n = 1;
    idle(3);
    check("R9", pulses, 0, "pulses after reset release");

    for (int src = 0; src < 7; src++) begin
      for (int m = 0; m < 32; m++) begin
        @(negedge clk);
        {en_wake, en_addr, en_rx, en_txi, en_txe} = m[4:0];
        clk_off = (src == 5);
        idle(3);
        clear_win();
        case (src)
          0: begin txe_flag = 1; expv = m[0]; tag = "R1"; end
          1: begin txi_flag = 1; expv = m[1]; tag = "R2"; end
          2: begin rxa_flag = 1; expv = m[2]; tag = "R3"; end
          3: begin rxo_flag = 1; expv = m[2]; tag = "R3"; end
          4: begin addr_hit = 1; expv = m[3]; tag = "R4"; end
          5: begin rx_pin = 0; expv = m[4] & m[2]; tag = "R5"; end
          default: begin rx_pin = 0; expv = 0; tag = "R6"; end
        endcase
        @(negedge clk) addr_hit = 0;
        idle(7);
        // R8: a held level yields at most one pulse
        check(tag, pulses, expv, $sformatf("pulses src=%0d mask=%0d", src, m));
        // R7
        check("R7", lows, pulses, $sformatf("low cycles src=%0d mask=%0d", src, m));
        clear_win();
        txe_flag = 0; txi_flag = 0; rxa_flag = 0; rxo_flag = 0; rx_pin = 1;
        idle(6);
        // R6: rising pin edge and flag removal give nothing
        check("R6", pulses, 0, $sformatf("pulses on release src=%0d mask=%0d", src, m));
      end
    end

    // R5 latency
    @(negedge clk);
    {en_wake, en_addr, en_rx, en_txi, en_txe} = 5'b10100;
    clk_off = 1;
    idle(3);
    rx_pin = 0;
    lat = 0;
    for (int k = 1; k <= 8; k++) begin
      @(posedge clk); #2;
      if (!irq_n && lat == 0) lat = k;
    end
    check("R5", lat, SYNC + 1, "wake latency in cycles");
    @(negedge clk) rx_pin = 1;
    clk_off = 0;
    idle(6);

    // R8 overlap
    {en_wake, en_addr, en_rx, en_txi, en_txe} = 5'b01111;
    clear_win();
    txe_flag = 1;
    idle(3);
    rxa_flag = 1;
    idle(2);
    addr_hit = 1;
    @(negedge clk) addr_hit = 0;
    txi_flag = 1;
    idle(5);
    check("R8", pulses, 1, "pulses with overlapping sources");
    txe_flag = 0; txi_flag = 0; rxa_flag = 0;
    idle(4);
    clear_win();
    rxo_flag = 1;
    idle(4);
    check("R8", pulses, 1, "new pulse after all sources cleared");
    rxo_flag = 0;
    idle(4);

    // R9 reset mid-stream
    txe_flag = 1;
    rst_n = 0;
    idle(2);
    check("R9", int'(irq_n), 1, "irq_n under reset with source active");
    txe_flag = 0;
    rst_n = 1;
    idle(3);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule